// File: doc/BRIEF.md
# Serial Bus Frame Deframer

This block sits behind a bit sampler on the receive side of a time-triggered automotive serial bus. Each sampled line level arrives as `bit_in` with a one-cycle `bit_valid` strobe. Cycles without the strobe carry no information. The block tracks the line from idle through the low start period and the frame body to the closing idle period.

Inside the body, a 1,0 separator pair comes before every eight data bits. The deframer removes these pairs, checks them, and counts only the data bits. From the first forty data bits it decodes the header: the flag bits, the identifier, the length, the header check value and the cycle counter. It then emits the payload one byte at a time. The payload holds twice as many bytes as the length field states. After the payload it hands the 24-bit trailer check value to a separate checker.

After the trailer the deframer reads the end sequence, tells a static ending from a dynamic one, and counts out the idle delimiter. It then reports the whole frame with a single pulse. A start that does not carry the frame pattern is reported as a collision avoidance symbol, and the block goes back to waiting for the next start.

Top module: `frx_deframer`

## Requirements
- R1: After synchronous reset, every pulse output (`hdr_valid`, `byte_valid`, `trl_valid`, `frame_done`, `cas_det`) is 0, and `hdr_id`, `frame_error` and `frame_dynamic` are 0.
- R2: While idle, a 0 bit starts the low start period. The first 1 bit after it is frame bit 0. The next two raw bits must be 1 then 0. If either of them differs, `cas_det` pulses, no header is reported, and the block waits for a new low period.
- R3: Before every group of eight data bits, the block removes a raw 1,0 separator pair, which is not counted as frame bits. A wrong pair after the first one does not break alignment, but it sets `frame_error` at the end of the frame.
- R4: Data bits are numbered from 1. Bit 1 is the reserved flag, bit 2 the preamble flag, bit 3 the data flag (0 marks a null frame), bit 4 the sync flag and bit 5 the startup flag. Bits 6..16 are the identifier, bits 17..23 the length, bits 24..34 the header check value and bits 35..40 the cycle counter, each MSB first. `hdr_valid` pulses for one cycle after data bit 40, and the fields hold until the next header.
- R5: Exactly 2×length payload bytes follow, taken from data bits 41 up to 40+16×length, MSB first. Each byte is presented on `byte_data` with a one-cycle `byte_valid`. A length of 0 gives no bytes.
- R6: The 24 data bits after the payload form `trl_crc`, MSB first, marked by a one-cycle `trl_valid`. No separator pair follows them.
- R7: The two raw bits after the trailer must be 1 then 0. Any other value sets `frame_error`.
- R8: If the raw bit after the end sequence is 0, the frame is dynamic. Further 0 bits extend the trailing sequence, and the first 1 closes it. `frame_dynamic` reports this with `frame_done`.
- R9: The idle delimiter has 11 bits. For a static frame it starts with the 1 right after the end sequence. For a dynamic frame it starts after the 1 that closes the trailing sequence. `frame_done` pulses one cycle after its 11th bit, together with `frame_error` and `frame_dynamic`, and the block returns to idle.
- R10: A frame whose identifier is 0 reports `frame_error` = 1 at `frame_done`.
- R11: When `bit_valid` is 0, `bit_in` is ignored. Every output changes only in the cycle after an accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe marking a sampled bus bit |
| bit_in | input | 1 | Sampled line level (1 = recessive) |
| hdr_valid | output | 1 | Header fields updated (one cycle) |
| hdr_reserved | output | 1 | Reserved flag |
| hdr_preamble | output | 1 | Payload preamble flag |
| hdr_has_data | output | 1 | 1 = data frame, 0 = null frame |
| hdr_sync | output | 1 | Sync flag |
| hdr_startup | output | 1 | Startup flag |
| hdr_id | output | 11 | Frame identifier |
| hdr_len | output | 7 | Length field (payload bytes / 2) |
| hdr_crc | output | 11 | Received header check value |
| hdr_cycle | output | 6 | Cycle counter |
| byte_valid | output | 1 | Payload byte strobe |
| byte_data | output | 8 | Payload byte |
| trl_valid | output | 1 | Trailer check value strobe |
| trl_crc | output | 24 | Received trailer check value |
| frame_done | output | 1 | Frame completed (one cycle) |
| frame_error | output | 1 | Framing or identifier fault in the finished frame |
| frame_dynamic | output | 1 | Finished frame ended dynamically |
| cas_det | output | 1 | Collision avoidance symbol seen (one cycle) |

## Verification
The assertions take for granted that `bit_valid` stays low during reset. They also assume that once a body has started, the stream keeps going until the delimiter, so header and trailer strobes always fall inside one frame that later completes. The stimulus drives random levels on `bit_in` during strobe gaps, but it only ever produces whole frames, or starts that break at one of the two separator positions after frame bit 0. A broken start is always followed by recessive idle, so no stray low period opens another body.

// File: rtl/frx_pkg.sv
package frx_pkg;
    localparam int ID_W     = 11;
    localparam int LEN_W    = 7;
    localparam int HCRC_W   = 11;
    localparam int CYC_W    = 6;
    localparam int TCRC_W   = 24;
    localparam int FLAG_N   = 5;
    localparam int HDR_BITS = FLAG_N + ID_W + LEN_W + HCRC_W + CYC_W;
    localparam int POS_W    = 12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_TSS, ST_BODY, ST_FES_HI, ST_FES_LO, ST_TAIL, ST_DTS, ST_CID
    } frx_state_e;

    // Field order equals arrival order, so the header shift register casts directly.
    typedef struct packed {
        logic              reserved;
        logic              preamble;
        logic              has_data;
        logic              sync;
        logic              startup;
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [HCRC_W-1:0] hcrc;
        logic [CYC_W-1:0]  cycle;
    } frx_hdr_t;

    // Index of the last payload data bit (payload is 16 bits per length unit).
    function automatic logic [POS_W-1:0] payload_end(input logic [LEN_W-1:0] len);
        return POS_W'(HDR_BITS) + (POS_W'(len) << 4);
    endfunction
endpackage

// File: rtl/frx_byte_slicer.sv
module frx_byte_slicer #(
    parameter int GROUP = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic en,
    input  logic bit_valid,
    input  logic bit_in,
    output logic data_stb,
    output logic group_last,
    output logic sep_bad
);
    localparam int PH_MAX = GROUP + 1;
    localparam int PH_W   = $clog2(GROUP + 2);

    logic [PH_W-1:0] phase;
    logic            take;

    assign take = en && bit_valid;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (take) begin
            phase <= (phase == PH_W'(PH_MAX)) ? '0 : phase + PH_W'(1);
        end
    end

    always_comb begin
        data_stb   = take && (phase >= PH_W'(2));
        group_last = data_stb && (phase == PH_W'(PH_MAX));
        sep_bad    = take && (((phase == PH_W'(0)) && !bit_in) ||
                              ((phase == PH_W'(1)) &&  bit_in));
    end
endmodule

// File: rtl/frx_hdr_capture.sv
module frx_hdr_capture
    import frx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     shift_en,
    input  logic     latch,
    input  logic     bit_in,
    output frx_hdr_t hdr,
    output logic     hdr_valid
);
    logic [HDR_BITS-2:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            hdr       <= '0;
            hdr_valid <= 1'b0;
        end else begin
            hdr_valid <= 1'b0;
            if (shift_en) begin
                sr <= {sr[HDR_BITS-3:0], bit_in};
            end
            if (latch) begin
                hdr       <= frx_hdr_t'({sr, bit_in});
                hdr_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/frx_deframer.sv
module frx_deframer
    import frx_pkg::*;
#(
    parameter int CID_LEN = 11,
    parameter int BYTE_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_valid,
    input  logic                bit_in,
    output logic                hdr_valid,
    output logic                hdr_reserved,
    output logic                hdr_preamble,
    output logic                hdr_has_data,
    output logic                hdr_sync,
    output logic                hdr_startup,
    output logic [ID_W-1:0]     hdr_id,
    output logic [LEN_W-1:0]    hdr_len,
    output logic [HCRC_W-1:0]   hdr_crc,
    output logic [CYC_W-1:0]    hdr_cycle,
    output logic                byte_valid,
    output logic [BYTE_W-1:0]   byte_data,
    output logic                trl_valid,
    output logic [TCRC_W-1:0]   trl_crc,
    output logic                frame_done,
    output logic                frame_error,
    output logic                frame_dynamic,
    output logic                cas_det
);
    localparam int CID_W = $clog2(CID_LEN);

    frx_state_e         state;
    logic [POS_W-1:0]   cnt;
    logic [POS_W-1:0]   cur;
    logic [POS_W-1:0]   pend;
    logic [CID_W-1:0]   cidc;
    logic [BYTE_W-2:0]  bsh;
    logic [TCRC_W-2:0]  tsh;
    logic               err;
    logic               dyn;
    logic               in_hdr, in_pay, in_trl, last_trl;
    logic               data_stb, group_last, sep_bad, restart;
    frx_hdr_t           hdr;

    assign restart = (state == ST_TSS) && bit_valid && bit_in;

    frx_byte_slicer #(.GROUP(BYTE_W)) u_slicer (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .en         (state == ST_BODY),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .data_stb   (data_stb),
        .group_last (group_last),
        .sep_bad    (sep_bad)
    );

    always_comb begin
        cur      = cnt + POS_W'(1);
        pend     = payload_end(hdr.len);
        in_hdr   = cur <= POS_W'(HDR_BITS);
        in_pay   = !in_hdr && (cur <= pend);
        in_trl   = !in_hdr && !in_pay;
        last_trl = cur == (pend + POS_W'(TCRC_W));
    end

    frx_hdr_capture u_hdr (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (data_stb && in_hdr),
        .latch     (data_stb && (cur == POS_W'(HDR_BITS))),
        .bit_in    (bit_in),
        .hdr       (hdr),
        .hdr_valid (hdr_valid)
    );

    assign hdr_reserved = hdr.reserved;
    assign hdr_preamble = hdr.preamble;
    assign hdr_has_data = hdr.has_data;
    assign hdr_sync     = hdr.sync;
    assign hdr_startup  = hdr.startup;
    assign hdr_id       = hdr.id;
    assign hdr_len      = hdr.len;
    assign hdr_crc      = hdr.hcrc;
    assign hdr_cycle    = hdr.cycle;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cnt           <= '0;
            cidc          <= '0;
            bsh           <= '0;
            tsh           <= '0;
            err           <= 1'b0;
            dyn           <= 1'b0;
            byte_valid    <= 1'b0;
            byte_data     <= '0;
            trl_valid     <= 1'b0;
            trl_crc       <= '0;
            frame_done    <= 1'b0;
            frame_error   <= 1'b0;
            frame_dynamic <= 1'b0;
            cas_det       <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            trl_valid  <= 1'b0;
            frame_done <= 1'b0;
            cas_det    <= 1'b0;
            if (bit_valid) begin
                unique case (state)
                    ST_IDLE: if (!bit_in) state <= ST_TSS;
                    ST_TSS: begin
                        if (bit_in) begin
                            state <= ST_BODY;
                            cnt   <= '0;
                            err   <= 1'b0;
                            dyn   <= 1'b0;
                        end
                    end
                    ST_BODY: begin
                        if (sep_bad && (cnt == '0)) begin
                            cas_det <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            if (sep_bad) err <= 1'b1;
                            if (data_stb) begin
                                cnt <= cur;
                                if (in_pay) begin
                                    bsh <= {bsh[BYTE_W-3:0], bit_in};
                                    if (group_last) begin
                                        byte_valid <= 1'b1;
                                        byte_data  <= {bsh, bit_in};
                                    end
                                end
                                if (in_trl) begin
                                    tsh <= {tsh[TCRC_W-3:0], bit_in};
                                    if (last_trl) begin
                                        trl_valid <= 1'b1;
                                        trl_crc   <= {tsh, bit_in};
                                        state     <= ST_FES_HI;
                                    end
                                end
                            end
                        end
                    end
                    ST_FES_HI: begin
                        if (!bit_in) err <= 1'b1;
                        state <= ST_FES_LO;
                    end
                    ST_FES_LO: begin
                        if (bit_in) err <= 1'b1;
                        state <= ST_TAIL;
                    end
                    ST_TAIL: begin
                        if (!bit_in) begin
                            dyn   <= 1'b1;
                            state <= ST_DTS;
                        end else begin
                            cidc  <= CID_W'(1);
                            state <= ST_CID;
                        end
                    end
                    ST_DTS: begin
                        if (bit_in) begin
                            cidc  <= '0;
                            state <= ST_CID;
                        end
                    end
                    ST_CID: begin
                        if (cidc == CID_W'(CID_LEN - 1)) begin
                            frame_done    <= 1'b1;
                            frame_error   <= err || (hdr.id == '0);
                            frame_dynamic <= dyn;
                            state         <= ST_IDLE;
                        end else begin
                            cidc <= cidc + CID_W'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/frx_deframer_chk.sv
module frx_deframer_chk (
    input logic        clk,
    input logic        rst,
    input logic        bit_valid,
    input logic        hdr_valid,
    input logic        byte_valid,
    input logic        trl_valid,
    input logic        frame_done,
    input logic        frame_error,
    input logic        cas_det,
    input logic [10:0] hdr_id
);
    logic hdr_seen;
    logic trl_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_seen <= 1'b0;
            trl_seen <= 1'b0;
        end else if (frame_done) begin
            hdr_seen <= 1'b0;
            trl_seen <= 1'b0;
        end else begin
            if (hdr_valid) hdr_seen <= 1'b1;
            if (trl_valid) trl_seen <= 1'b1;
        end
    end

    // R11: every strobe follows an accepted bit
    assert_strobe_after_bit_R11: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid || byte_valid || trl_valid || frame_done || cas_det) |-> $past(bit_valid));

    // R9: strobes belong to distinct bits
    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hdr_valid, byte_valid, trl_valid, frame_done, cas_det}));

    // R4: payload bytes only after the header was reported
    assert_hdr_before_byte_R4: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> hdr_seen);

    // R5: no payload byte after the trailer value
    assert_no_byte_after_trl_R5: assert property (@(posedge clk) disable iff (rst)
        trl_seen |-> !byte_valid);

    // R6: completion only after the trailer value was delivered
    assert_trl_before_done_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> trl_seen);

    // R10: zero identifier is flagged
    assert_zero_id_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (frame_done && (hdr_id == 11'd0)) |-> frame_error);
endmodule

bind frx_deframer frx_deframer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_valid   (bit_valid),
    .hdr_valid   (hdr_valid),
    .byte_valid  (byte_valid),
    .trl_valid   (trl_valid),
    .frame_done  (frame_done),
    .frame_error (frame_error),
    .cas_det     (cas_det),
    .hdr_id      (hdr_id)
);

// File: tb/frx_deframer_tb.sv
module frx_deframer_tb;
    logic clk = 1'b0;
    logic rst;
    logic bit_valid;
    logic bit_in;
    logic hdr_valid, hdr_reserved, hdr_preamble, hdr_has_data, hdr_sync, hdr_startup;
    logic [10:0] hdr_id;
    logic [6:0]  hdr_len;
    logic [10:0] hdr_crc;
    logic [5:0]  hdr_cycle;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        trl_valid;
    logic [23:0] trl_crc;
    logic        frame_done, frame_error, frame_dynamic, cas_det;

    always #4 clk = ~clk;

    frx_deframer u_dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .hdr_valid(hdr_valid), .hdr_reserved(hdr_reserved), .hdr_preamble(hdr_preamble),
        .hdr_has_data(hdr_has_data), .hdr_sync(hdr_sync), .hdr_startup(hdr_startup),
        .hdr_id(hdr_id), .hdr_len(hdr_len), .hdr_crc(hdr_crc), .hdr_cycle(hdr_cycle),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .trl_valid(trl_valid), .trl_crc(trl_crc),
        .frame_done(frame_done), .frame_error(frame_error),
        .frame_dynamic(frame_dynamic), .cas_det(cas_det)
    );

    int total = 0;
    int bad   = 0;
    int gap_max = 0;

    int n_hdr, n_byte, n_trl, n_done, n_cas;
    logic [7:0]  got_b [0:255];
    logic [7:0]  exp_b [0:255];
    logic [39:0] got_hdr;
    logic [23:0] got_trl;
    logic        g_err, g_dyn;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (hdr_valid) begin
                n_hdr++;
                got_hdr = {hdr_reserved, hdr_preamble, hdr_has_data, hdr_sync, hdr_startup,
                           hdr_id, hdr_len, hdr_crc, hdr_cycle};
            end
            if (byte_valid) begin
                if (n_byte < 256) got_b[n_byte] = byte_data;
                n_byte++;
            end
            if (trl_valid) begin
                n_trl++;
                got_trl = trl_crc;
            end
            if (frame_done) begin
                n_done++;
                g_err = frame_error;
                g_dyn = frame_dynamic;
            end
            if (cas_det) n_cas++;
        end
    end

    task automatic clear_mon();
        n_hdr = 0; n_byte = 0; n_trl = 0; n_done = 0; n_cas = 0;
        g_err = 1'b0; g_dyn = 1'b0;
    endtask

    task automatic put_bit(input logic b);
        int g;
        g = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
        repeat (g) begin
            @(posedge clk); #2;
            bit_valid = 1'b0;
            bit_in    = 1'($urandom_range(1, 0));
        end
        @(posedge clk); #2;
        bit_valid = 1'b1;
        bit_in    = b;
    endtask

    task automatic settle();
        @(posedge clk); #2;
        bit_valid = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    function automatic logic [39:0] make_hv(input logic [4:0] flags, input logic [10:0] id,
                                           input logic [6:0] len, input logic [10:0] hc,
                                           input logic [5:0] cyc);
        return {flags, id, len, hc, cyc};
    endfunction

    task automatic send_frame(input logic [39:0] hv, input logic [23:0] tcrc, input bit dynamic,
                              input int dts_n, input int bad_sep, input bit bad_fes);
        int nb;
        int len;
        logic [7:0] by;
        len = int'(hv[23:17]);
        nb  = 5 + 2 * len + 3;
        clear_mon();
        repeat (2) put_bit(1'b1);
        repeat (3) put_bit(1'b0);
        put_bit(1'b1);
        for (int k = 0; k < nb; k++) begin
            if (k < 5)                by = hv[39 - 8 * k -: 8];
            else if (k < 5 + 2 * len) by = exp_b[k - 5];
            else                      by = tcrc[23 - 8 * (k - 5 - 2 * len) -: 8];
            put_bit(1'b1);
            put_bit((k == bad_sep) ? 1'b1 : 1'b0);
            for (int b = 7; b >= 0; b--) put_bit(by[b]);
        end
        put_bit(1'b1);
        put_bit(bad_fes ? 1'b1 : 1'b0);
        if (dynamic) begin
            put_bit(1'b0);
            repeat (dts_n) put_bit(1'b0);
            put_bit(1'b1);
        end
        repeat (11) put_bit(1'b1);
        settle();
    endtask

    task automatic check_frame(input string tag, input logic [39:0] hv, input logic [23:0] tcrc,
                               input bit dyn, input bit exp_err, input string err_req);
        int len;
        len = int'(hv[23:17]);
        chk("R9", {tag, " done count"}, n_done, 1);
        chk("R2", {tag, " no cas"}, n_cas, 0);
        chk("R4", {tag, " header count"}, n_hdr, 1);
        chk("R4", {tag, " header fields"}, got_hdr, hv);
        chk("R5", {tag, " byte count"}, n_byte, 2 * len);
        for (int i = 0; i < 2 * len && i < n_byte; i++)
            chk("R5", {tag, " byte value"}, got_b[i], exp_b[i]);
        chk("R6", {tag, " trailer count"}, n_trl, 1);
        chk("R6", {tag, " trailer value"}, got_trl, tcrc);
        chk("R8", {tag, " dynamic flag"}, g_dyn, dyn);
        chk(err_req, {tag, " error flag"}, g_err, exp_err);
    endtask

    task automatic fill_payload(input int len);
        for (int i = 0; i < 2 * len; i++) exp_b[i] = 8'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [39:0] hv;
        logic [23:0] tc;
        void'($urandom(32'h1F2E3D4C));
        rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b1;
        clear_mon();
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset pulses", {hdr_valid, byte_valid, trl_valid, frame_done, cas_det}, 0);
        chk("R1", "reset id", hdr_id, 0);
        chk("R1", "reset flags", {frame_error, frame_dynamic}, 0);

        // static frame, contiguous bits
        hv = make_hv(5'b00110, 11'd5, 7'd2, 11'h2A5, 6'd17);
        tc = 24'hC3A55A; fill_payload(2);
        send_frame(hv, tc, 1'b0, 0, -1, 1'b0);
        check_frame("static", hv, tc, 1'b0, 1'b0, "R7");

        // dynamic frame with trailing zeros, strobe gaps (R8, R11)
        gap_max = 2;
        hv = make_hv(5'b01111, 11'd1234, 7'd3, 11'h1F0, 6'd63);
        tc = 24'h123456; fill_payload(3);
        send_frame(hv, tc, 1'b1, 4, -1, 1'b0);
        check_frame("dynamic", hv, tc, 1'b1, 1'b0, "R11");

        // empty payload (R5)
        hv = make_hv(5'b10000, 11'd2047, 7'd0, 11'h7FF, 6'd0);
        tc = 24'hFFFFFF;
        send_frame(hv, tc, 1'b0, 0, -1, 1'b0);
        check_frame("len0", hv, tc, 1'b0, 1'b0, "R5");

        // zero identifier (R10)
        hv = make_hv(5'b00100, 11'd0, 7'd1, 11'h001, 6'd9);
        tc = 24'h0F0F0F; fill_payload(1);
        send_frame(hv, tc, 1'b0, 0, -1, 1'b0);
        check_frame("id0", hv, tc, 1'b0, 1'b1, "R10");

        // bad separator pair in byte group 3 (R3)
        hv = make_hv(5'b00100, 11'd77, 7'd2, 11'h155, 6'd40);
        tc = 24'hABCDEF; fill_payload(2);
        send_frame(hv, tc, 1'b0, 0, 3, 1'b0);
        check_frame("badsep", hv, tc, 1'b0, 1'b1, "R3");

        // bad end sequence (R7)
        hv = make_hv(5'b00100, 11'd300, 7'd1, 11'h0AA, 6'd1);
        tc = 24'h600D00; fill_payload(1);
        send_frame(hv, tc, 1'b1, 0, -1, 1'b1);
        check_frame("badfes", hv, tc, 1'b1, 1'b1, "R7");

        // collision symbol: second separator bit high (R2)
        clear_mon();
        repeat (2) put_bit(1'b1);
        repeat (4) put_bit(1'b0);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        repeat (20) put_bit(1'b1);
        settle();
        chk("R2", "cas count a", n_cas, 1);
        chk("R2", "cas no header a", n_hdr + n_done, 0);

        // collision symbol: first separator bit low (R2)
        clear_mon();
        repeat (3) put_bit(1'b0);
        put_bit(1'b1); put_bit(1'b0);
        repeat (20) put_bit(1'b1);
        settle();
        chk("R2", "cas count b", n_cas, 1);
        chk("R2", "cas no header b", n_hdr + n_done, 0);

        // longest payload (R5)
        hv = make_hv(5'b00111, 11'd999, 7'd127, 11'h321, 6'd33);
        tc = 24'h5A5A5A; fill_payload(127);
        send_frame(hv, tc, 1'b0, 0, -1, 1'b0);
        check_frame("maxlen", hv, tc, 1'b0, 1'b0, "R5");

        // random frames with strobe gaps (R11)
        for (int f = 0; f < 8; f++) begin
            logic [10:0] id;
            logic [6:0]  ln;
            bit          dy;
            id = (f == 5) ? 11'd0 : 11'($urandom_range(2047, 1));
            ln = 7'($urandom_range(24, 0));
            dy = 1'($urandom_range(1, 0));
            hv = make_hv(5'($urandom), id, ln, 11'($urandom), 6'($urandom));
            tc = 24'($urandom);
            fill_payload(int'(ln));
            send_frame(hv, tc, dy, int'($urandom_range(5, 0)), -1, 1'b0);
            check_frame("random", hv, tc, dy, (id == 11'd0), "R11");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule